// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests from peripherals and from the CPU core, picks the single most urgent pending request, and hands its 16-bit vector address to the CPU when the CPU asks for one. Maskable peripheral requests, one separately maskable request, a software/debug request, an unimplemented-opcode trap and three reset sources all share one lookup. Each maps to a fixed low byte, and a programmable base byte supplies the high byte. The reset sources are the exception: they use absolute addresses.

A CPU vector fetch is a two-state handshake. In `ST_IDLE` the block waits for `vec_req`. When the request is sampled, the transition `IDLE->DRIVE` captures the winning address. `ST_DRIVE` presents that address with `vec_valid` for exactly one cycle. The transition `DRIVE->IDLE` is unconditional. While the CPU sleeps in wait or stop mode the block's clock is off, so the wake-up output is purely combinational from the request and mask inputs. An active debug freeze overrides the programmed base byte.

Top module: `intvec_ctrl`

## Requirements
- R1: The base byte resets to 0xFF. A write on `base_wr_en` takes effect from the next clock edge. For every non-reset vector, `vec_addr[15:8]` equals the effective base byte.
- R2: Maskable request `irq_req[k]` uses low byte 0xF2 − 2·k. Among such requests the lowest index wins.
- R3: While `i_mask` is 1, every `irq_req` bit is ignored by both selection and wake-up.
- R4: `xirq_req` uses low byte 0xF4 and beats every `irq_req`. While `x_mask` is 1 it is ignored.
- R5: `swi_req` uses low byte 0xF6, cannot be masked, and beats `xirq_req`.
- R6: `trap_req` uses low byte 0xF8 and beats `swi_req`.
- R7: `rst_src[2]`, `rst_src[1]` and `rst_src[0]` select the absolute addresses 0xFFFE, 0xFFFC and 0xFFFA, in that priority order. They beat every other request and do not depend on the base byte.
- R8: A `vec_req` sampled in `ST_IDLE` makes `vec_valid` 1 for exactly the following cycle. A `vec_req` sampled in `ST_DRIVE` is ignored.
- R9: When no request qualifies, the delivered address is base:0x80.
- R10: While `freeze` is 1 the effective base byte is 0xFF. The programmed value returns when `freeze` drops.
- R11: In wait mode, `wake` is 1 when there is any unmasked `irq_req` or any unmasked `xirq_req`.
- R12: In stop mode, `wake` counts only an unmasked `irq_req[k]` whose `stop_wake_en[k]` is 1, or an unmasked `xirq_req`.
- R13: With neither `wait_mode` nor `stop_mode` set, `wake` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_wr_en | input | 1 | Write strobe for the base byte |
| base_wr_data | input | 8 | New base byte |
| freeze | input | 1 | Debug freeze active; forces the base byte to 0xFF |
| irq_req | input | NUM_IRQ | Maskable requests; index 0 is the most urgent |
| stop_wake_en | input | NUM_IRQ | Per-request enable for waking from stop |
| i_mask | input | 1 | Mask for `irq_req` |
| xirq_req | input | 1 | Separately maskable request |
| x_mask | input | 1 | Mask for `xirq_req` |
| swi_req | input | 1 | Software interrupt or debug entry request |
| trap_req | input | 1 | Unimplemented-opcode trap |
| rst_src | input | 3 | Reset sources, bit 2 most urgent |
| wait_mode | input | 1 | CPU is in wait mode |
| stop_mode | input | 1 | CPU is in stop mode |
| vec_req | input | 1 | CPU asks for a vector |
| vec_valid | output | 1 | `vec_addr` is valid this cycle |
| vec_addr | output | 16 | Selected vector address |
| wake | output | 1 | Combinational wake-up request |

## Verification
The bench drives every request class and several of them at once, so that a priority ladder with any two rungs swapped delivers the wrong low byte. It also checks that the reset vectors keep their 0xFF high byte under an arbitrary base, which a design that merged the base into them would fail. Masked requests are shown to fall through to the next class or to the empty vector 0x80. A `vec_req` held across the drive cycle must not produce a second pulse, which exposes a handshake that re-arms from `ST_DRIVE`. Freeze must override the base without losing the programmed value. The wake-up output is checked in run, wait and stop modes, including a request whose stop enable is clear.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
    typedef enum logic {ST_IDLE, ST_DRIVE} vec_state_e;

    localparam logic [7:0] LO_IRQ_TOP  = 8'hF2;
    localparam logic [7:0] LO_XIRQ     = 8'hF4;
    localparam logic [7:0] LO_SWI      = 8'hF6;
    localparam logic [7:0] LO_TRAP     = 8'hF8;
    localparam logic [7:0] LO_NONE     = 8'h80;
    localparam logic [7:0] LO_RST_HI   = 8'hFE;
    localparam logic [7:0] LO_RST_MID  = 8'hFC;
    localparam logic [7:0] LO_RST_LO   = 8'hFA;
    localparam logic [7:0] BASE_RESET  = 8'hFF;
    localparam logic [7:0] BASE_FREEZE = 8'hFF;
    localparam logic [7:0] ABS_HI      = 8'hFF;
endpackage

// File: rtl/intvec_base_reg.sv
module intvec_base_reg
    import intvec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       freeze,
    output logic [7:0] eff_base
);
    logic [7:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     base_q <= BASE_RESET;
        else if (wr_en) base_q <= wr_data;
    end

    assign eff_base = freeze ? BASE_FREEZE : base_q;
endmodule

// File: rtl/intvec_arbiter.sv
module intvec_arbiter
    import intvec_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               i_mask,
    input  logic               xirq_req,
    input  logic               x_mask,
    input  logic               swi_req,
    input  logic               trap_req,
    input  logic [2:0]         rst_src,
    output logic               sel_abs,
    output logic [7:0]         sel_low
);
    logic [NUM_IRQ-1:0] irq_live;
    assign irq_live = i_mask ? '0 : irq_req;

    always_comb begin
        sel_abs = 1'b0;
        sel_low = LO_NONE;
        // lowest-urgency classes first; each later hit overrides
        for (int k = NUM_IRQ - 1; k >= 0; k--) begin
            if (irq_live[k]) sel_low = LO_IRQ_TOP - 8'(2 * k);
        end
        if (xirq_req && !x_mask) sel_low = LO_XIRQ;
        if (swi_req)             sel_low = LO_SWI;
        if (trap_req)            sel_low = LO_TRAP;
        if (|rst_src) begin
            sel_abs = 1'b1;
            if (rst_src[2])      sel_low = LO_RST_HI;
            else if (rst_src[1]) sel_low = LO_RST_MID;
            else                 sel_low = LO_RST_LO;
        end
    end
endmodule

// File: rtl/intvec_wake.sv
module intvec_wake #(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] stop_wake_en,
    input  logic               i_mask,
    input  logic               xirq_req,
    input  logic               x_mask,
    input  logic               wait_mode,
    input  logic               stop_mode,
    output logic               wake
);
    logic [NUM_IRQ-1:0] run_q, stop_q;

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_qual
        assign run_q[k]  = irq_req[k] && !i_mask;
        assign stop_q[k] = run_q[k] && stop_wake_en[k];
    end

    logic x_live;
    assign x_live = xirq_req && !x_mask;

    assign wake = (wait_mode && (|run_q || x_live)) ||
                  (stop_mode && (|stop_q || x_live));
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
    import intvec_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               base_wr_en,
    input  logic [7:0]         base_wr_data,
    input  logic               freeze,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic [NUM_IRQ-1:0] stop_wake_en,
    input  logic               i_mask,
    input  logic               xirq_req,
    input  logic               x_mask,
    input  logic               swi_req,
    input  logic               trap_req,
    input  logic [2:0]         rst_src,
    input  logic               wait_mode,
    input  logic               stop_mode,
    input  logic               vec_req,
    output logic               vec_valid,
    output logic [15:0]        vec_addr,
    output logic               wake
);
    logic [7:0] eff_base;
    logic       sel_abs;
    logic [7:0] sel_low;

    intvec_base_reg u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .freeze  (freeze),
        .eff_base(eff_base)
    );

    intvec_arbiter #(.NUM_IRQ(NUM_IRQ)) u_arb (
        .irq_req (irq_req),
        .i_mask  (i_mask),
        .xirq_req(xirq_req),
        .x_mask  (x_mask),
        .swi_req (swi_req),
        .trap_req(trap_req),
        .rst_src (rst_src),
        .sel_abs (sel_abs),
        .sel_low (sel_low)
    );

    intvec_wake #(.NUM_IRQ(NUM_IRQ)) u_wake (
        .irq_req     (irq_req),
        .stop_wake_en(stop_wake_en),
        .i_mask      (i_mask),
        .xirq_req    (xirq_req),
        .x_mask      (x_mask),
        .wait_mode   (wait_mode),
        .stop_mode   (stop_mode),
        .wake        (wake)
    );

    vec_state_e state_q, state_d;
    logic [15:0] addr_q;
    logic        capture;

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (vec_req) begin
                    state_d = ST_DRIVE;
                    capture = 1'b1;
                end
            end
            ST_DRIVE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (capture) addr_q <= {sel_abs ? ABS_HI : eff_base, sel_low};
        end
    end

    always_comb begin
        vec_valid = (state_q == ST_DRIVE);
        vec_addr  = addr_q;
    end
endmodule

// File: rtl/intvec_ctrl_chk.sv
module intvec_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       vec_req,
    input logic       vec_valid,
    input logic [7:0] addr_hi,
    input logic       addr_lsb,
    input logic       freeze,
    input logic [2:0] rst_src,
    input logic       wait_mode,
    input logic       stop_mode,
    input logic       wake
);
    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_req_answered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_valid) |=> vec_valid);

    assert_even_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !addr_lsb);

    assert_reset_abs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_valid && |rst_src) |=> (addr_hi == 8'hFF));

    assert_freeze_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_req && !vec_valid && freeze) |=> (addr_hi == 8'hFF));

    assert_no_wake_run_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!wait_mode && !stop_mode) |-> !wake);
endmodule

bind intvec_ctrl intvec_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .vec_req  (vec_req),
    .vec_valid(vec_valid),
    .addr_hi  (vec_addr[15:8]),
    .addr_lsb (vec_addr[0]),
    .freeze   (freeze),
    .rst_src  (rst_src),
    .wait_mode(wait_mode),
    .stop_mode(stop_mode),
    .wake     (wake)
);

// File: tb/intvec_ctrl_tb_top.sv
module intvec_ctrl_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         base_wr_en = 1'b0;
    logic [7:0]   base_wr_data = '0;
    logic         freeze = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] stop_wake_en = '0;
    logic         i_mask = 1'b0;
    logic         xirq_req = 1'b0;
    logic         x_mask = 1'b0;
    logic         swi_req = 1'b0;
    logic         trap_req = 1'b0;
    logic [2:0]   rst_src = '0;
    logic         wait_mode = 1'b0;
    logic         stop_mode = 1'b0;
    logic         vec_req = 1'b0;
    logic         vec_valid;
    logic [15:0]  vec_addr;
    logic         wake;

    always #10 clk = ~clk;

    intvec_ctrl #(.NUM_IRQ(N)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    logic [7:0]  model_base = 8'hFF;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_vec();
        logic [7:0] b = freeze ? 8'hFF : model_base;
        if (rst_src[2]) return 16'hFFFE;
        if (rst_src[1]) return 16'hFFFC;
        if (rst_src[0]) return 16'hFFFA;
        if (trap_req) return {b, 8'hF8};
        if (swi_req) return {b, 8'hF6};
        if (xirq_req && !x_mask) return {b, 8'hF4};
        for (int k = 0; k < N; k++)
            if (irq_req[k] && !i_mask) return {b, 8'hF2 - 8'(2 * k)};
        return {b, 8'h80};
    endfunction

    // driver: pushes the expected vector, then pulses the request
    task automatic fetch(string req, int hold = 1);
        @(negedge clk);
        exp_q.push_back(model_vec());
        tag_q.push_back(req);
        vec_req = 1'b1;
        repeat (hold) @(negedge clk);
        vec_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic clear_reqs();
        irq_req = '0; xirq_req = 0; swi_req = 0; trap_req = 0; rst_src = '0;
        i_mask = 0; x_mask = 0;
    endtask

    task automatic write_base(logic [7:0] v);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
        model_base = v;
    endtask

    // monitor: compares each delivered vector against the queue head
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (exp_q.size() == 0) begin
                check("R8 spurious vec_valid", vec_addr, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), vec_addr, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic wake_chk(string req, logic exp);
        #1 check(req, {15'd0, wake}, {15'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset vec_valid R8", {15'd0, vec_valid}, 16'd0);
        check("reset wake R13", {15'd0, wake}, 16'd0);

        fetch("R9 empty vector, R1 reset base");
        irq_req = 8'b0000_0100; fetch("R2 single irq 2");
        irq_req = 8'b1001_0100; fetch("R2 lowest index wins");
        irq_req = 8'b1000_0000; fetch("R2 irq 7");
        write_base(8'h3C);
        irq_req = 8'b0000_0001; fetch("R1 new base, R2 irq 0");
        i_mask = 1; fetch("R3 masked irq, R9 fallback");
        xirq_req = 1; fetch("R4 x over masked irq");
        i_mask = 0; fetch("R4 x beats irq 0");
        x_mask = 1; fetch("R4 x masked, irq wins");
        swi_req = 1; x_mask = 0; fetch("R5 swi beats x");
        i_mask = 1; x_mask = 1; fetch("R5 swi not maskable");
        trap_req = 1; fetch("R6 trap beats swi");
        rst_src = 3'b001; fetch("R7 reset lo");
        rst_src = 3'b011; fetch("R7 reset mid");
        rst_src = 3'b111; fetch("R7 reset hi");
        clear_reqs();
        freeze = 1; swi_req = 1; fetch("R10 freeze forces base");
        freeze = 0; fetch("R10 base restored");
        clear_reqs();
        irq_req = 8'b0010_0000; fetch("R8 held request single pulse", 2);
        write_base(8'h00);
        fetch("R1 base 00, R8 re-armed");
        clear_reqs();

        @(negedge clk);
        irq_req = 8'b0000_1000; wake_chk("R13 run mode no wake", 0);
        wait_mode = 1;          wake_chk("R11 wait wake irq", 1);
        i_mask = 1;             wake_chk("R11 R3 masked no wake", 0);
        xirq_req = 1;           wake_chk("R11 wait wake x", 1);
        x_mask = 1;             wake_chk("R11 R4 x masked no wake", 0);
        clear_reqs(); wait_mode = 0; stop_mode = 1;
        irq_req = 8'b0000_1000; wake_chk("R12 stop without enable", 0);
        stop_wake_en = 8'b0000_1000; wake_chk("R12 stop with enable", 1);
        i_mask = 1;             wake_chk("R12 stop masked", 0);
        xirq_req = 1;           wake_chk("R12 stop x", 1);
        stop_mode = 0;          wake_chk("R13 back to run", 0);
        clear_reqs();

        repeat (4) @(negedge clk);
        check("R8 all vectors delivered", 16'(exp_q.size()), 16'd0);
        finish_run();
    end
endmodule